// File: doc/BRIEF.md
# Victim Line Buffer

This block sits beside a direct-mapped or low-associativity cache. It keeps a small, fully associative set of lines that the cache recently threw out. When the cache misses, the missing line address is looked up here. On a hit, the cache takes the returned line and hands back the line it is replacing, and that line takes the hit entry's slot. This two-way exchange gives conflicting lines more effective associativity. On a miss, the line the cache evicts is written in. If the buffer is full, the entry that was written longest ago is pushed out, and a dirty one leaves through the writeback stream.

Lookups, fills and writebacks are valid/ready streams. A transfer happens on a clock edge where both valid and ready are high.
- A lookup is refused while a response waits unconsumed.
- A fill is refused while a writeback waits unconsumed.
- Both are refused in any cycle where the plain invalidate pin is high.
- A producer that sees ready low keeps its valid and payload unchanged.

Each entry holds a full line address, a 64-byte line, a valid flag and a dirty flag. Eight entries is the default.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is empty. `rs_valid` and `wb_valid` are low, and any lookup misses.
- R2: A lookup accepted at edge N gives `rs_valid` high after edge N.
  - `rs_hit` is 1 when a valid entry holds exactly `lk_addr`. `rs_data` and `rs_dirty` are then that entry's line and dirty flag.
  - Otherwise `rs_hit` is 0.
  - The response reflects the contents before any fill or invalidate taking effect at the same edge.
- R3: While `rs_valid` is high and `rs_ready` is low, the response holds stable and `lk_ready` is low.
- R4: A fill with `put_swap`=1 whose `put_match_addr` is held overwrites that entry in place with `put_addr`, `put_data` and `put_dirty`. It makes no writeback and leaves every other entry unchanged.
- R5: A fill into a buffer with an empty entry uses an empty entry and makes no writeback.
- R6: A fill into a full buffer displaces the entry written longest ago. A swap-in counts as a write. A dirty displaced entry appears on `wb_addr`/`wb_data` with `wb_valid` after the accepting edge. A clean one is dropped silently.
- R7: While `wb_valid` is high and `wb_ready` is low, the writeback holds stable and `put_ready` is low.
- R8: `inv_valid` removes the entry holding `inv_addr`, with no writeback. An absent address changes nothing. While `inv_valid` is high, `lk_ready` and `put_ready` are low.
- R9: The dirty flag travels with its line. A dirty line that was swapped in is written back when it is later displaced.
- R10: After an invalidate, the next fill takes the freed entry. Later displacements still follow the write order of the remaining entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_addr | input | ADDR_W | Line address to look up |
| rs_valid | output | 1 | Lookup response valid |
| rs_ready | input | 1 | Lookup response consumed |
| rs_hit | output | 1 | Lookup found the line |
| rs_dirty | output | 1 | Dirty flag of the found line |
| rs_data | output | LINE_BYTES*8 | Found line data (zero on miss) |
| put_valid | input | 1 | Fill request valid |
| put_ready | output | 1 | Fill request accepted |
| put_swap | input | 1 | 1: exchange with the entry holding `put_match_addr`; 0: plain insert |
| put_match_addr | input | ADDR_W | Address of the entry being exchanged |
| put_addr | input | ADDR_W | Line address of the incoming line |
| put_data | input | LINE_BYTES*8 | Incoming line data |
| put_dirty | input | 1 | Incoming line is dirty |
| wb_valid | output | 1 | Writeback of a displaced dirty line valid |
| wb_ready | input | 1 | Writeback consumed |
| wb_addr | output | ADDR_W | Line address of the written-back line |
| wb_data | output | LINE_BYTES*8 | Written-back line data |
| inv_valid | input | 1 | Invalidate strobe |
| inv_addr | input | ADDR_W | Line address to invalidate |

## Verification
The hardest state to reach from the ports is a full buffer whose write order differs from its slot order. This happens after swaps refresh an entry in place, or after an invalidate leaves a hole that a later fill reuses. The stimulus fills all eight slots, swaps one line out of the middle, and invalidates another. It then keeps inserting until every original line has been pushed out. The order and dirtiness of the lines on the writeback stream show whether the recency order was kept. Back-pressure on the response and writeback streams is applied separately while an entry is pending.

// File: rtl/victim_buf_pkg.sv
package victim_buf_pkg;
  // How an accepted fill picks its target slot.
  typedef enum logic [1:0] {
    FILL_NONE,    // no fill this cycle
    FILL_HIT,     // key already held: overwrite in place
    FILL_FREE,    // an empty slot exists
    FILL_OLDEST   // buffer full: displace the least recently written slot
  } fill_e;
endpackage

// File: rtl/victim_buf_cam.sv
module victim_buf_cam #(
  parameter int N  = 8,
  parameter int AW = 26,
  parameter int IW = 3
) (
  input  logic [N-1:0]    vld,
  input  logic [N*AW-1:0] tags,
  input  logic [AW-1:0]   key,
  output logic            hit,
  output logic [IW-1:0]   idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = vld[g] && (tags[g*AW +: AW] == key);
  end

  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (eq[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/victim_buf_free.sv
module victim_buf_free #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vld,
  output logic          any_free,
  output logic [IW-1:0] free_idx
);
  // Lowest-numbered empty slot wins.
  always_comb begin
    any_free = ~&vld;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IW'(i);
    end
  end
endmodule

// File: rtl/victim_buf_age.sv
// Relative write-order ranks: valid entries always carry ranks 0..count-1,
// 0 being the most recently written.
module victim_buf_age #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vld,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  input  logic          drop_en,
  input  logic [IW-1:0] drop_idx,
  output logic [N*IW-1:0] age_flat,
  output logic [IW-1:0] oldest_idx
);
  logic [IW-1:0] age_q [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= '0;
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) begin
          age_q[i] <= '0;
        end else if (vld[i] && (!vld[touch_idx] || age_q[i] < age_q[touch_idx])) begin
          age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end else if (drop_en) begin
      for (int i = 0; i < N; i++) begin
        if (vld[i] && age_q[i] > age_q[drop_idx]) age_q[i] <= age_q[i] - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign age_flat[g*IW +: IW] = age_q[g];
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && age_q[i] == IW'(N - 1)) oldest_idx = IW'(i);
    end
  end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
  import victim_buf_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  output logic                    lk_ready,
  input  logic [ADDR_W-1:0]       lk_addr,
  output logic                    rs_valid,
  input  logic                    rs_ready,
  output logic                    rs_hit,
  output logic                    rs_dirty,
  output logic [LINE_BYTES*8-1:0] rs_data,
  input  logic                    put_valid,
  output logic                    put_ready,
  input  logic                    put_swap,
  input  logic [ADDR_W-1:0]       put_match_addr,
  input  logic [ADDR_W-1:0]       put_addr,
  input  logic [LINE_BYTES*8-1:0] put_data,
  input  logic                    put_dirty,
  output logic                    wb_valid,
  input  logic                    wb_ready,
  output logic [ADDR_W-1:0]       wb_addr,
  output logic [LINE_BYTES*8-1:0] wb_data,
  input  logic                    inv_valid,
  input  logic [ADDR_W-1:0]       inv_addr
);
  localparam int LW = LINE_BYTES * 8;
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Entry storage
  logic [ADDR_W-1:0]     tag_q  [ENTRIES];
  logic [LW-1:0]         data_q [ENTRIES];
  logic [ENTRIES-1:0]    vld_q, dirty_q;
  logic [ENTRIES*ADDR_W-1:0] tags_flat;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tags
    assign tags_flat[g*ADDR_W +: ADDR_W] = tag_q[g];
  end

  // Handshakes
  logic lk_fire, put_fire;
  assign lk_ready  = !inv_valid && (!rs_valid || rs_ready);
  assign put_ready = !inv_valid && (!wb_valid || wb_ready);
  assign lk_fire   = lk_valid && lk_ready;
  assign put_fire  = put_valid && put_ready;

  // Associative searches
  logic          lk_hit, put_hit, inv_hit;
  logic [IW-1:0] lk_idx, put_idx, inv_idx;
  logic [ADDR_W-1:0] put_key;
  assign put_key = put_swap ? put_match_addr : put_addr;

  victim_buf_cam #(.N(ENTRIES), .AW(ADDR_W), .IW(IW)) u_cam_lk (
    .vld(vld_q), .tags(tags_flat), .key(lk_addr), .hit(lk_hit), .idx(lk_idx));
  victim_buf_cam #(.N(ENTRIES), .AW(ADDR_W), .IW(IW)) u_cam_put (
    .vld(vld_q), .tags(tags_flat), .key(put_key), .hit(put_hit), .idx(put_idx));
  victim_buf_cam #(.N(ENTRIES), .AW(ADDR_W), .IW(IW)) u_cam_inv (
    .vld(vld_q), .tags(tags_flat), .key(inv_addr), .hit(inv_hit), .idx(inv_idx));

  logic          any_free;
  logic [IW-1:0] free_idx;
  victim_buf_free #(.N(ENTRIES), .IW(IW)) u_free (
    .vld(vld_q), .any_free(any_free), .free_idx(free_idx));

  // Target selection
  fill_e         kind;
  logic [IW-1:0] tgt_idx, oldest_idx;
  logic          inv_fire, need_wb;
  logic [ENTRIES*IW-1:0] age_flat;

  always_comb begin
    if (!put_fire)      kind = FILL_NONE;
    else if (put_hit)   kind = FILL_HIT;
    else if (any_free)  kind = FILL_FREE;
    else                kind = FILL_OLDEST;
    unique case (kind)
      FILL_HIT:  tgt_idx = put_idx;
      FILL_FREE: tgt_idx = free_idx;
      default:   tgt_idx = oldest_idx;
    endcase
  end

  assign inv_fire = inv_valid && inv_hit;
  assign need_wb  = (kind == FILL_OLDEST) && dirty_q[oldest_idx];

  victim_buf_age #(.N(ENTRIES), .IW(IW)) u_age (
    .clk(clk), .rst_n(rst_n), .vld(vld_q),
    .touch_en(put_fire), .touch_idx(tgt_idx),
    .drop_en(inv_fire), .drop_idx(inv_idx),
    .age_flat(age_flat), .oldest_idx(oldest_idx));

  // Flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      dirty_q <= '0;
    end else if (put_fire) begin
      vld_q[tgt_idx]   <= 1'b1;
      dirty_q[tgt_idx] <= put_dirty;
    end else if (inv_fire) begin
      vld_q[inv_idx]   <= 1'b0;
      dirty_q[inv_idx] <= 1'b0;
    end
  end

  // Payload (no reset needed)
  always_ff @(posedge clk) begin
    if (put_fire) begin
      tag_q[tgt_idx]  <= put_addr;
      data_q[tgt_idx] <= put_data;
    end
  end

  // Lookup response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_dirty <= 1'b0;
    end else if (lk_fire) begin
      rs_valid <= 1'b1;
      rs_hit   <= lk_hit;
      rs_dirty <= lk_hit && dirty_q[lk_idx];
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_fire) rs_data <= lk_hit ? data_q[lk_idx] : '0;
  end

  // Writeback of displaced dirty lines
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
    end else if (need_wb) begin
      wb_valid <= 1'b1;
    end else if (wb_ready) begin
      wb_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (need_wb) begin
      wb_addr <= tag_q[oldest_idx];
      wb_data <= data_q[oldest_idx];
    end
  end
endmodule

// File: rtl/victim_buffer_chk.sv
module victim_buffer_chk #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 26,
  parameter int LW      = 512,
  parameter int IW      = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lk_valid,
  input logic                  lk_ready,
  input logic                  rs_valid,
  input logic                  rs_ready,
  input logic                  rs_hit,
  input logic                  rs_dirty,
  input logic [LW-1:0]         rs_data,
  input logic                  put_valid,
  input logic                  put_ready,
  input logic                  wb_valid,
  input logic                  wb_ready,
  input logic [ADDR_W-1:0]     wb_addr,
  input logic [LW-1:0]         wb_data,
  input logic                  inv_valid,
  input logic [ENTRIES-1:0]    vld_q,
  input logic [ENTRIES*IW-1:0] age_flat
);
  logic [ENTRIES-1:0] at_newest, at_oldest;
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      at_newest[i] = vld_q[i] && (age_flat[i*IW +: IW] == '0);
      at_oldest[i] = vld_q[i] && (age_flat[i*IW +: IW] == IW'(ENTRIES - 1));
    end
  end

  a_r2_rsp_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rs_valid) |-> $past(lk_valid && lk_ready));

  a_r3_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_hit) && $stable(rs_dirty) && $stable(rs_data));

  a_r3_lk_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |-> !lk_ready);

  a_r6_wb_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(put_valid && put_ready));

  a_r6_one_newest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(at_newest));

  a_r6_full_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    &vld_q |-> $countones(at_oldest) == 1);

  a_r7_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

  a_r7_put_stall: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |-> !put_ready);

  a_r8_inv_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !lk_ready && !put_ready);
endmodule

bind victim_buffer victim_buffer_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LW(LW), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit),
  .rs_dirty(rs_dirty), .rs_data(rs_data),
  .put_valid(put_valid), .put_ready(put_ready),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
  .inv_valid(inv_valid), .vld_q(vld_q), .age_flat(age_flat)
);

// File: tb/tb_victim_buffer.sv
module tb_victim_buffer;
  localparam int AW = 26;
  localparam int LW = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, rs_ready = 1'b1, put_valid = 1'b0, put_swap = 1'b0;
  logic put_dirty = 1'b0, wb_ready = 1'b1, inv_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0, put_match_addr = '0, put_addr = '0, inv_addr = '0;
  logic [LW-1:0] put_data = '0;
  logic lk_ready, rs_valid, rs_hit, rs_dirty, put_ready, wb_valid;
  logic [LW-1:0] rs_data, wb_data;
  logic [AW-1:0] wb_addr;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  victim_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit),
    .rs_dirty(rs_dirty), .rs_data(rs_data),
    .put_valid(put_valid), .put_ready(put_ready), .put_swap(put_swap),
    .put_match_addr(put_match_addr), .put_addr(put_addr),
    .put_data(put_data), .put_dirty(put_dirty),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
    .inv_valid(inv_valid), .inv_addr(inv_addr)
  );

  function automatic logic [LW-1:0] line_of(logic [15:0] a);
    return {16{~a, a}};
  endfunction

  task automatic chk(string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Vector: op[53:52] a[51:36] m[35:20] d[19] eh[18] ed[17] ew[16] ewa[15:0]
  // op: 0 lookup, 1 insert, 2 swap, 3 invalidate
  localparam int NV = 36;
  localparam logic [53:0] VEC [NV] = '{
    {2'd0, 16'h0001, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R1 empty miss
    {2'd1, 16'h0010, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R5 fill
    {2'd1, 16'h0011, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd1, 16'h0012, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd1, 16'h0013, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd1, 16'h0014, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd1, 16'h0015, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd1, 16'h0016, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd1, 16'h0017, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd0, 16'h0013, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0},   // R2 dirty hit
    {2'd0, 16'h0012, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0},   // R2 clean hit
    {2'd2, 16'h0020, 16'h0012, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0}, // R4 swap
    {2'd0, 16'h0012, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd0, 16'h0020, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0},
    {2'd0, 16'h0016, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0},
    {2'd1, 16'h0030, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R6 clean out
    {2'd1, 16'h0031, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0011}, // R6 dirty out
    {2'd0, 16'h0010, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd3, 16'h0014, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R8
    {2'd0, 16'h0014, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd1, 16'h0032, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0},   // R10 takes hole
    {2'd1, 16'h0033, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0013}, // R10 order kept
    {2'd1, 16'h0034, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0015},
    {2'd1, 16'h0035, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd1, 16'h0036, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0017},
    {2'd1, 16'h0037, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0020}, // R9 swapped dirty
    {2'd2, 16'h0040, 16'h0030, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0}, // R4
    {2'd0, 16'h0030, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd0, 16'h0040, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0},
    {2'd1, 16'h0041, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd1, 16'h0042, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0032},
    {2'd3, 16'h00FF, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R8 absent
    {2'd1, 16'h0043, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0},
    {2'd0, 16'h0034, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0},
    {2'd0, 16'h0035, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0},
    {2'd1, 16'h0044, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0}
  };

  task automatic do_lookup(string req, logic [15:0] a, logic eh, logic ed);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = AW'(a);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(req, "rs_valid", LW'(rs_valid), LW'(1'b1));
    chk(req, "rs_hit", LW'(rs_hit), LW'(eh));
    if (eh) begin
      chk(req, "rs_dirty", LW'(rs_dirty), LW'(ed));
      chk(req, "rs_data", rs_data, line_of(a));
    end
  endtask

  task automatic do_put(string req, logic sw, logic [15:0] a, logic [15:0] m, logic d,
                        logic ew, logic [15:0] ewa);
    @(negedge clk);
    put_valid = 1'b1; put_swap = sw; put_addr = AW'(a); put_match_addr = AW'(m);
    put_data = line_of(a); put_dirty = d;
    @(negedge clk);
    put_valid = 1'b0;
    chk(req, "wb_valid", LW'(wb_valid), LW'(ew));
    if (ew) begin
      chk(req, "wb_addr", LW'(wb_addr), LW'(AW'(ewa)));
      chk(req, "wb_data", wb_data, line_of(ewa));
    end
  endtask

  task automatic do_inv(logic [15:0] a);
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = AW'(a);
    @(negedge clk);
    inv_valid = 1'b0;
    chk("R8", "wb_valid after invalidate", LW'(wb_valid), LW'(1'b0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rs_valid after reset", LW'(rs_valid), LW'(1'b0));
    chk("R1", "wb_valid after reset", LW'(wb_valid), LW'(1'b0));
    chk("R1", "ready after reset", LW'({lk_ready, put_ready}), LW'(2'b11));

    for (int i = 0; i < NV; i++) begin
      logic [53:0] v;
      v = VEC[i];
      case (v[53:52])
        2'd0: do_lookup("R2", v[51:36], v[18], v[17]);
        2'd1: do_put(v[16] ? "R6" : "R5", 1'b0, v[51:36], 16'h0, v[19], v[16], v[15:0]);
        2'd2: do_put("R4", 1'b1, v[51:36], v[35:20], v[19], v[16], v[15:0]);
        default: do_inv(v[51:36]);
      endcase
    end
    // Order now, oldest first: 35(dirty) 36 37 40 41 42 43 44

    // R3: response held under back-pressure
    rs_ready = 1'b0;
    do_lookup("R3", 16'h0036, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R3", "rs_valid held", LW'(rs_valid), LW'(1'b1));
      chk("R3", "rs_data held", rs_data, line_of(16'h0036));
      chk("R3", "lk_ready low", LW'(lk_ready), LW'(1'b0));
    end
    rs_ready = 1'b1;
    @(negedge clk);
    chk("R3", "rs_valid released", LW'(rs_valid), LW'(1'b0));

    // R7: writeback held under back-pressure, fills stalled
    wb_ready = 1'b0;
    do_put("R7", 1'b0, 16'h0045, 16'h0, 1'b0, 1'b1, 16'h0035);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7", "wb_valid held", LW'(wb_valid), LW'(1'b1));
      chk("R7", "wb_addr held", LW'(wb_addr), LW'(AW'(16'h0035)));
      chk("R7", "put_ready low", LW'(put_ready), LW'(1'b0));
    end
    wb_ready = 1'b1;
    @(negedge clk);
    chk("R7", "wb_valid released", LW'(wb_valid), LW'(1'b0));

    // R8: invalidate strobe blocks both request streams
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = AW'(16'h00EE);
    #1;
    chk("R8", "ready during invalidate", LW'({lk_ready, put_ready}), LW'(2'b00));
    @(negedge clk);
    inv_valid = 1'b0;
    do_lookup("R8", 16'h0036, 1'b1, 1'b0);

    // R1: reset in the middle of a run empties the buffer
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "rs_valid after rerun reset", LW'(rs_valid), LW'(1'b0));
    do_lookup("R1", 16'h0036, 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule